// File: doc/BRIEF.md
# Double-Buffered PWM Channel Period

This block is one PWM channel built around a 16-bit counter. Software writes a new period through a write-only update port. The value lands in a shadow register. The shadow value is copied into the live period only when the running period finishes. Because of this, a period change never cuts a cycle short or stretches it.

The counter advances on ticks from a tick source that the clock-select input picks. The source is either a power-of-two prescaler of the master clock or one of two linear dividers with an 8-bit factor. The counter runs in one of two modes:
- Left-aligned: the counter wraps back to zero.
- Center-aligned: the counter climbs to the period value and then falls back to zero, which doubles the output period.

The output is high while the counter is below a fixed duty compare value. Two protect flags, one set by software and one by hardware, can each block period writes. A one-cycle pulse marks every period boundary, which is also the moment a new period takes effect.

Top module: `pwm_period_chan`

## Requirements
- R1: A write with both protect flags low stores bits [15:0] of the written word in the shadow register, and bits [31:16] have no effect on the period.
- R2: A write while either `wp_sw_i` or `wp_hw_i` is high leaves the shadow register, and so the period, unchanged.
- R3: The shadow value becomes the active period only at a period end. A write made mid-period does not alter the length of that period, and the period after the next end uses the new value.
- R4: In left-aligned mode (`center_i`=0), with active period P>0, the counter visits 0..P-1, so the time between period ends is P*X master clock cycles, where X is the tick divisor.
- R5: In center-aligned mode (`center_i`=1), the counter visits 0 up to P and back down to 1, so the time between period ends is 2*P*X cycles.
- R6: `clk_sel_i` values 0 to 10 select the prescaler, with X = 2^`clk_sel_i`.
- R7: `clk_sel_i`=11 selects linear divider A and 12 selects linear divider B, with X equal to that divider's factor. A factor of 0, or a `clk_sel_i` value of 13 to 15, stops the counter: there are no period ends and `pwm_o` holds.
- R8: `pwm_o` is high exactly while the counter is below `duty_i`. The high time per period is min(D,P)*X when left-aligned. When center-aligned it is 0 for D=0, (2D-1)*X for 1<=D<=P, and 2P*X for D>P.
- R9: `period_end_o` is a one-master-cycle pulse in the cycle after the counter returns to 0. With an active period of 0 the counter stays at 0 and every tick is a period end.
- R10: After reset the counter is 0, both the active and shadow periods are 0, and `period_end_o` is low while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Period update write strobe |
| wr_data_i | input | 32 | Period update word (low 16 bits used) |
| wp_sw_i | input | 1 | Software write-protect flag |
| wp_hw_i | input | 1 | Hardware write-protect flag |
| clk_sel_i | input | 4 | Tick source: 0-10 prescaler, 11 divider A, 12 divider B |
| div_a_i | input | 8 | Linear divider A factor (0 = off) |
| div_b_i | input | 8 | Linear divider B factor (0 = off) |
| center_i | input | 1 | 1 = center-aligned, 0 = left-aligned |
| duty_i | input | 16 | Duty compare value |
| pwm_o | output | 1 | PWM waveform |
| period_end_o | output | 1 | One-cycle period-end pulse |

## Verification
Some properties are checked by assertions on every cycle:
- the active period holds between period ends and is loaded from the shadow at each end;
- a protected write leaves the shadow unchanged;
- an accepted write stores only the low half of the word, even when the upper half is non-zero;
- the counter moves only on ticks;
- each period-end pulse coincides with a zero count.

The bench scenarios cover what the assertions cannot:
- the actual period lengths and high times for every prescaler setting, for several divider factors and in both alignments;
- the rule that a mid-period write leaves the running period alone;
- a stopped counter when a divider is off or an unused select value is chosen.

// File: rtl/pwm_period_pkg.sv
package pwm_period_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned PRE_N  = 11;  // prescaler taps 2^0..2^(PRE_N-1)
  localparam int unsigned N_LIN  = 2;   // linear dividers
  localparam int unsigned DIV_W  = 8;
  localparam int unsigned SEL_W  = 4;
endpackage

// File: rtl/pwm_lin_div.sv
module pwm_lin_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] factor_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign tick_o  = (factor_i != '0) && (cnt_inc >= {1'b0, factor_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (factor_i == '0 || tick_o)      cnt_q <= '0;
    else                                    cnt_q <= cnt_inc[DIV_W-1:0];
  end

  AST_DIV_OFF_RESTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (factor_i == '0) |=> (cnt_q == '0));  // R7
endmodule

// File: rtl/pwm_tick_sel.sv
module pwm_tick_sel #(
  parameter int unsigned PRE_N = 11,
  parameter int unsigned N_LIN = 2,
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_LIN-1:0] lin_tick_i,
  output logic             tick_o
);
  localparam int unsigned PRE_W = (PRE_N > 1) ? PRE_N - 1 : 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_N-1:0] pow_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  // tap k fires once every 2^k cycles
  for (genvar k = 0; k < PRE_N; k++) begin : g_tap
    if (k == 0) begin : g_div1
      assign pow_tick[k] = 1'b1;
    end else begin : g_divn
      assign pow_tick[k] = &pre_q[k-1:0];
    end
  end

  always_comb begin
    tick_o = 1'b0;
    for (int k = 0; k < PRE_N; k++)
      if (sel_i == SEL_W'(k)) tick_o = pow_tick[k];
    for (int j = 0; j < N_LIN; j++)
      if (sel_i == SEL_W'(PRE_N + j)) tick_o = lin_tick_i[j];
  end

  AST_UNUSED_SEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i >= SEL_W'(PRE_N + N_LIN)) |-> !tick_o);  // R7
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              center_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wp_sw_i,
  input  logic              wp_hw_i,
  input  logic [CNT_W-1:0]  duty_i,
  output logic              pwm_o,
  output logic              period_end_o
);
  logic [CNT_W-1:0] shadow_q, prd_q, cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic             down_q, down_d, end_c, wr_ok;

  assign wr_ok   = wr_en_i & ~wp_sw_i & ~wp_hw_i;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = 1'b0;
    end_c  = 1'b0;
    if (prd_q == '0) begin
      cnt_d = '0;
      end_c = 1'b1;
    end else if (!center_i) begin
      if (cnt_inc >= {1'b0, prd_q}) begin
        cnt_d = '0;
        end_c = 1'b1;
      end else begin
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end else if (down_q || cnt_q >= prd_q) begin
      // falling half; also recovers a count left above the period
      if (cnt_q <= CNT_W'(1)) begin
        cnt_d = '0;
        end_c = 1'b1;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        down_d = 1'b1;
      end
    end else begin
      cnt_d  = cnt_inc[CNT_W-1:0];
      down_d = (cnt_inc >= {1'b0, prd_q});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q     <= '0;
      prd_q        <= '0;
      cnt_q        <= '0;
      down_q       <= 1'b0;
      period_end_o <= 1'b0;
    end else begin
      if (wr_ok) shadow_q <= wr_data_i[CNT_W-1:0];
      period_end_o <= tick_i & end_c;
      if (tick_i) begin
        cnt_q  <= cnt_d;
        down_q <= down_d;
        if (end_c) prd_q <= shadow_q;
      end
    end
  end

  assign pwm_o = (cnt_q < duty_i);

  AST_WR_LOW_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && wr_data_i[DATA_W-1:CNT_W] != '0) |=>
      (shadow_q == $past(wr_data_i[CNT_W-1:0])));  // R1
  AST_WP_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wp_sw_i || wp_hw_i)) |=> $stable(shadow_q));  // R2
  AST_PRD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end_o |-> $stable(prd_q));  // R3
  AST_PRD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(period_end_o) |-> (prd_q == $past(shadow_q)));  // R3
  AST_CNT_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));  // R7
  AST_END_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |-> (cnt_q == '0));  // R9
endmodule

// File: rtl/pwm_period_chan.sv
module pwm_period_chan
  import pwm_period_pkg::*;
#(
  parameter int unsigned P_CNT_W  = CNT_W,
  parameter int unsigned P_DATA_W = DATA_W,
  parameter int unsigned P_PRE_N  = PRE_N,
  parameter int unsigned P_DIV_W  = DIV_W,
  parameter int unsigned P_SEL_W  = SEL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [P_DATA_W-1:0] wr_data_i,
  input  logic                wp_sw_i,
  input  logic                wp_hw_i,
  input  logic [P_SEL_W-1:0]  clk_sel_i,
  input  logic [P_DIV_W-1:0]  div_a_i,
  input  logic [P_DIV_W-1:0]  div_b_i,
  input  logic                center_i,
  input  logic [P_CNT_W-1:0]  duty_i,
  output logic                pwm_o,
  output logic                period_end_o
);
  localparam int unsigned NL = N_LIN;

  logic [NL-1:0]      lin_tick;
  logic [P_DIV_W-1:0] lin_factor [NL];
  logic               tick;

  assign lin_factor[0] = div_a_i;
  assign lin_factor[1] = div_b_i;

  for (genvar j = 0; j < NL; j++) begin : g_lin
    pwm_lin_div #(.DIV_W(P_DIV_W)) u_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .factor_i (lin_factor[j]),
      .tick_o   (lin_tick[j])
    );
  end

  pwm_tick_sel #(.PRE_N(P_PRE_N), .N_LIN(NL), .SEL_W(P_SEL_W)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (clk_sel_i),
    .lin_tick_i (lin_tick),
    .tick_o     (tick)
  );

  pwm_chan_core #(.CNT_W(P_CNT_W), .DATA_W(P_DATA_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .center_i     (center_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .wp_sw_i      (wp_sw_i),
    .wp_hw_i      (wp_hw_i),
    .duty_i       (duty_i),
    .pwm_o        (pwm_o),
    .period_end_o (period_end_o)
  );
endmodule

// File: tb/pwm_period_chan_test.sv
module pwm_period_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wp_sw = 1'b0, wp_hw = 1'b0;
  logic [3:0]  clk_sel = '0;
  logic [7:0]  div_a = 8'd1, div_b = 8'd1;
  logic        center = 1'b0;
  logic [15:0] duty = 16'd5;
  logic        pwm, pend;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  pwm_period_chan uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wp_sw_i(wp_sw), .wp_hw_i(wp_hw), .clk_sel_i(clk_sel),
    .div_a_i(div_a), .div_b_i(div_b), .center_i(center), .duty_i(duty),
    .pwm_o(pwm), .period_end_o(pend)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_prd(input logic [31:0] d, input logic sw, input logic hw);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wp_sw = sw; wp_hw = hw;
    @(negedge clk);
    wr_en = 1'b0; wp_sw = 1'b0; wp_hw = 1'b0;
  endtask

  // advance to the next negedge with a period-end pulse
  task automatic sync();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pend && n < 40000);
    if (!pend) chk("R9", "sync timeout", 0, 1);
  endtask

  // assumes the current negedge shows a pulse; counts until the next one
  task automatic span(output int len, output int hi);
    len = 1; hi = int'(pwm);
    forever begin
      @(negedge clk);
      if (pend || len > 40000) break;
      len++; hi += int'(pwm);
    end
  endtask

  function automatic int exp_hi(input int p, input int d, input int x, input bit c);
    if (!c) return ((d < p) ? d : p) * x;
    if (d == 0) return 0;
    if (d > p) return 2 * p * x;
    return (2 * d - 1) * x;
  endfunction

  task automatic run_cfg(input string req, input int p, input int d,
                         input logic [3:0] sel, input bit c, input int x);
    int len, hi;
    clk_sel = sel; center = c; duty = 16'(d);
    write_prd(32'(p), 1'b0, 1'b0);
    sync();        // end of period in progress: new value loads here
    span(len, hi);
    chk(req, $sformatf("len p=%0d sel=%0d c=%0d", p, sel, c), len, c ? 2 * p * x : p * x);
    chk("R8", $sformatf("high p=%0d d=%0d sel=%0d c=%0d", p, d, sel, c), hi, exp_hi(p, d, x, c));
  endtask

  task automatic expect_stall(input string what);
    int pulses = 0;
    logic p0;
    repeat (3) @(negedge clk);
    p0 = pwm;
    repeat (3000) begin
      @(negedge clk);
      pulses += int'(pend);
      if (pwm !== p0) pulses += 1000;
    end
    chk("R7", what, pulses, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int len, hi;
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10", "pend in reset", int'(pend), 0);
    chk("R10", "pwm at zero count (duty 5)", int'(pwm), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R9: zero period, X=1 -> end on every cycle
    for (int i = 0; i < 3; i++) begin
      chk("R9", "zero period pulse each tick", int'(pend), 1);
      @(negedge clk);
    end

    // R4/R5/R6: all prescaler taps, both alignments
    for (int c = 0; c < 2; c++)
      for (int s = 0; s <= 10; s++)
        run_cfg(c ? "R5" : "R4", 3, 2, 4'(s), c[0], 1 << s);

    // R8: duty sweep at X=1 and X=2
    for (int c = 0; c < 2; c++)
      for (int d = 0; d <= 6; d++)
        run_cfg("R8", 4, d, 4'(d % 2), c[0], 1 + d % 2);

    // R7: linear dividers
    for (int f = 1; f <= 5; f++) begin
      div_a = 8'(f);
      run_cfg("R7", 3, 2, 4'd11, f[0], f);
    end
    div_b = 8'd7;
    run_cfg("R7", 2, 1, 4'd12, 1'b0, 7);
    run_cfg("R7", 2, 1, 4'd12, 1'b1, 7);

    // R1: upper half ignored
    run_cfg("R1", 4, 2, 4'd0, 1'b0, 1);
    clk_sel = 4'd1;
    write_prd(32'hABCD_0005, 1'b0, 1'b0);
    sync(); span(len, hi);
    chk("R1", "upper bits ignored", len, 10);

    // R2: protected writes ignored
    write_prd(32'h0000_0009, 1'b1, 1'b0);
    write_prd(32'h0000_000B, 1'b0, 1'b1);
    write_prd(32'h0000_000D, 1'b1, 1'b1);
    sync(); sync(); span(len, hi);
    chk("R2", "period after protected writes", len, 10);

    // R3: mid-period write does not touch the running period
    clk_sel = 4'd2;
    sync(); sync();
    fork
      span(len, hi);
      write_prd(32'h0000_0008, 1'b0, 1'b0);
    join
    chk("R3", "running period unchanged", len, 20);
    span(len, hi);
    chk("R3", "next period uses new value", len, 32);

    // R7: stopped tick sources
    clk_sel = 4'd13;
    expect_stall("select 13 stops counter");
    clk_sel = 4'd15;
    expect_stall("select 15 stops counter");
    div_a = 8'd0; clk_sel = 4'd11;
    expect_stall("divider A factor 0 stops counter");
    div_a = 8'd2;
    sync(); span(len, hi);
    chk("R7", "divider A resumes", len, 16);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule